// File: doc/BRIEF.md
# Gated 13-bit Timer/Counter Channel

This block is one channel of a small-controller timer in its 13-bit mode. The count lives in two software-visible registers. The low register uses only its five bottom bits for counting. The high register is a full byte that takes the carry out of the fifth low bit directly. The three top bits of the low register play no part in counting and simply keep whatever software last wrote into them.

The channel advances on one of two sources. In timer mode it counts system clock cycles through a prescaler that divides by 12 or by 4. In counter mode it counts falling edges on an external pin, after that pin has passed a two-flop synchronizer. A run bit enables counting. An optional gate makes counting depend on an external gate pin being high. When the count steps past all ones it wraps to zero and raises an overflow flag. The interrupt acknowledge input clears that flag. Software may also write the flag directly.

Top module: `timer13Gated`

## Requirements
- R1: After reset the low register, the high register and the overflow flag all read zero.
- R2: In timer mode (`countSel`=0) with `fastBase`=0, the count rises by one for every 12 enabled clock cycles. The first increment appears 12 cycles after the run bit is set.
- R3: In timer mode with `fastBase`=1, the count rises by one every 4 enabled cycles. The first increment appears 4 cycles after the run bit is set.
- R4: While `runEn` is 0 the count does not change in either mode, and the prescaler restarts from zero.
- R5: With `gateEn`=1, counting stops while `gatePin` is low and resumes while it is high. With `gateEn`=0, `gatePin` has no effect.
- R6: In counter mode (`countSel`=1) each 1-to-0 transition of `countPin` adds exactly one, three clock edges after the change. Rising edges and clock cycles add nothing.
- R7: The count is {high[7:0], low[4:0]}. A carry out of low bit 4 increments high bit 0. Low bits 7:5 hold their last written value.
- R8: One increment from 1FFFh gives 0000h and sets `ovfFlag`.
- R9: A one-cycle `intAck` clears `ovfFlag` on the next edge.
- R10: A write to the low or high register in a cycle that also carries an increment stores the written data. That increment is dropped for the whole count, and the prescaler still restarts.
- R11: `flagWrEn` loads `flagWrVal` into `ovfFlag`. Acknowledge beats the software write. A hardware overflow beats both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run bit |
| gateEn | input | 1 | Gate select: 1 makes counting depend on gatePin |
| gatePin | input | 1 | External gate pin |
| countSel | input | 1 | 0 counts clock ticks, 1 counts countPin falling edges |
| fastBase | input | 1 | Prescale select: 0 divides by 12, 1 divides by 4 |
| countPin | input | 1 | External count pin (asynchronous) |
| lowWrEn | input | 1 | Write strobe for the low register |
| highWrEn | input | 1 | Write strobe for the high register |
| wrData | input | 8 | Write data for both registers |
| flagWrEn | input | 1 | Software write strobe for the overflow flag |
| flagWrVal | input | 1 | Value written to the overflow flag |
| intAck | input | 1 | Interrupt acknowledge pulse |
| lowRd | output | 8 | Low register read value |
| highRd | output | 8 | High register read value |
| ovfFlag | output | 1 | Overflow flag |

## Verification
Two collisions matter here.

The first is a software register write landing in the same cycle as a prescaler increment. The bench asserts the low-register write exactly on the fourth enabled edge of a divide-by-4 run. It then expects the written value with no increment added. It also expects the next increment four cycles later, which shows the prescaler restarted.

The second is an overflow landing in the same cycle as an acknowledge and a software clear. The bench preloads 1FFEh and holds `intAck` and a flag write of 0 across the wrapping edge. It judges the result by the flag still reading 1 and the count reading zero.

// File: rtl/timer13Pkg.sv
package timer13Pkg;
  typedef struct packed {
    logic incr;
    logic wrLow;
    logic wrHigh;
  } ctlStrobes_t;
endpackage

// File: rtl/timer13Ctrl.sv
module timer13Ctrl
  import timer13Pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        gateEn,
  input  logic        gatePin,
  input  logic        countSel,
  input  logic        fastBase,
  input  logic        countPin,
  input  logic        lowWrEn,
  input  logic        highWrEn,
  output ctlStrobes_t strobes
);
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(DIV_SLOW - 1);
  localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(DIV_FAST - 1);

  // synchronizer stages plus one history flop for edge detection
  logic [SYNC_STAGES:0] pinPipe;
  logic [PRE_W-1:0]     preCnt;
  logic [PRE_W-1:0]     divLast;
  logic                 countOk;
  logic                 preTick;
  logic                 pinFall;

  always_ff @(posedge clk) begin
    if (!rstN) pinPipe <= '1;
    else       pinPipe <= {pinPipe[SYNC_STAGES-1:0], countPin};
  end

  assign pinFall = pinPipe[SYNC_STAGES] & ~pinPipe[SYNC_STAGES-1];
  assign countOk = runEn && (!gateEn || gatePin);
  assign divLast = fastBase ? LAST_FAST : LAST_SLOW;
  assign preTick = countOk && !countSel && (preCnt >= divLast);

  always_ff @(posedge clk) begin
    if (!rstN || !runEn || countSel) preCnt <= '0;
    else if (countOk)                preCnt <= preTick ? '0 : preCnt + PRE_W'(1);
  end

  always_comb begin
    strobes.incr   = countSel ? (countOk && pinFall) : preTick;
    strobes.wrLow  = lowWrEn;
    strobes.wrHigh = highWrEn;
  end

  AST_IDLE_NO_INCR: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !strobes.incr); // R4
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn && !gatePin) |-> !strobes.incr); // R5
  AST_RISE_NO_INCR: assert property (@(posedge clk) disable iff (!rstN)
    (countSel && pinPipe[SYNC_STAGES-1]) |-> !strobes.incr); // R6
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (preCnt <= LAST_SLOW)); // R2
endmodule

// File: rtl/timer13Datapath.sv
module timer13Datapath
  import timer13Pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LOW_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flagWrEn,
  input  logic              flagWrVal,
  input  logic              intAck,
  output logic [DATA_W-1:0] lowRd,
  output logic [DATA_W-1:0] highRd,
  output logic              ovfFlag
);
  localparam int SPARE_W = DATA_W - LOW_BITS;

  logic [LOW_BITS-1:0] lowCnt;
  logic [SPARE_W-1:0]  lowSpare;
  logic [DATA_W-1:0]   highCnt;
  logic                bump;
  logic                lowCarry;
  logic                allOnes;
  logic                wrapEvt;

  assign bump     = strobes.incr && !(strobes.wrLow || strobes.wrHigh);
  assign lowCarry = &lowCnt;
  assign allOnes  = lowCarry && (&highCnt);
  assign wrapEvt  = bump && allOnes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt   <= '0;
      lowSpare <= '0;
    end else if (strobes.wrLow) begin
      {lowSpare, lowCnt} <= wrData;
    end else if (bump) begin
      lowCnt <= lowCnt + LOW_BITS'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  highCnt <= '0;
    else if (strobes.wrHigh)    highCnt <= wrData;
    else if (bump && lowCarry)  highCnt <= highCnt + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         ovfFlag <= 1'b0;
    else if (wrapEvt)  ovfFlag <= 1'b1;
    else if (intAck)   ovfFlag <= 1'b0;
    else if (flagWrEn) ovfFlag <= flagWrVal;
  end

  assign lowRd  = {lowSpare, lowCnt};
  assign highRd = highCnt;

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (bump && allOnes) |=> (ovfFlag && lowCnt == '0 && highCnt == '0)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !(strobes.incr && allOnes)) |=> !ovfFlag); // R9
  AST_RIPPLE_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (bump && lowCarry && !allOnes) |=> (lowCnt == '0 && highCnt == $past(highCnt) + DATA_W'(1))); // R7
  AST_SPARE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrLow |=> $stable(lowSpare)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLow |=> (lowRd == $past(wrData))); // R10
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (bump && allOnes && intAck) |=> ovfFlag); // R11
endmodule

// File: rtl/timer13Gated.sv
module timer13Gated
  import timer13Pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LOW_BITS    = 5,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              gateEn,
  input  logic              gatePin,
  input  logic              countSel,
  input  logic              fastBase,
  input  logic              countPin,
  input  logic              lowWrEn,
  input  logic              highWrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flagWrEn,
  input  logic              flagWrVal,
  input  logic              intAck,
  output logic [DATA_W-1:0] lowRd,
  output logic [DATA_W-1:0] highRd,
  output logic              ovfFlag
);
  ctlStrobes_t strobes;

  timer13Ctrl #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .gateEn(gateEn), .gatePin(gatePin),
    .countSel(countSel), .fastBase(fastBase), .countPin(countPin),
    .lowWrEn(lowWrEn), .highWrEn(highWrEn), .strobes(strobes)
  );

  timer13Datapath #(
    .DATA_W(DATA_W), .LOW_BITS(LOW_BITS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .flagWrEn(flagWrEn), .flagWrVal(flagWrVal), .intAck(intAck),
    .lowRd(lowRd), .highRd(highRd), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/tb_timer13Gated.sv
module tb_timer13Gated;
  localparam real CLK_NS = 8.0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0, gateEn = 1'b0, gatePin = 1'b0;
  logic       countSel = 1'b0, fastBase = 1'b0, countPin = 1'b1;
  logic       lowWrEn = 1'b0, highWrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       flagWrEn = 1'b0, flagWrVal = 1'b0, intAck = 1'b0;
  logic [7:0] lowRd, highRd;
  logic       ovfFlag;

  int  checkCnt = 0;
  int  failCnt = 0;
  bit  finished = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  timer13Gated dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .gateEn(gateEn), .gatePin(gatePin),
    .countSel(countSel), .fastBase(fastBase), .countPin(countPin),
    .lowWrEn(lowWrEn), .highWrEn(highWrEn), .wrData(wrData),
    .flagWrEn(flagWrEn), .flagWrVal(flagWrVal), .intAck(intAck),
    .lowRd(lowRd), .highRd(highRd), .ovfFlag(ovfFlag)
  );

  function automatic logic [15:0] countNow();
    return {3'b000, highRd, lowRd[4:0]};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setCount(logic [7:0] lowVal, logic [7:0] highVal);
    lowWrEn = 1'b1; wrData = lowVal;
    tick(1);
    lowWrEn = 1'b0; highWrEn = 1'b1; wrData = highVal;
    tick(1);
    highWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "low after reset", {8'h0, lowRd}, 16'h0);
    check("R1", "high after reset", {8'h0, highRd}, 16'h0);
    check("R1", "flag after reset", {15'h0, ovfFlag}, 16'h0);
  endtask

  task automatic testDivFour();
    setCount(8'h00, 8'h00);
    countSel = 1'b0; fastBase = 1'b1; runEn = 1'b1;
    tick(3);  check("R3", "before first tick", countNow(), 16'd0);
    tick(1);  check("R3", "first tick", countNow(), 16'd1);
    tick(36); check("R3", "after 40 cycles", countNow(), 16'd10);
    runEn = 1'b0;
  endtask

  task automatic testDivTwelve();
    setCount(8'h00, 8'h00);
    countSel = 1'b0; fastBase = 1'b0; runEn = 1'b1;
    tick(11);  check("R2", "before first tick", countNow(), 16'd0);
    tick(1);   check("R2", "first tick", countNow(), 16'd1);
    tick(108); check("R2", "after 120 cycles", countNow(), 16'd10);
    runEn = 1'b0;
  endtask

  task automatic testRunOff();
    tick(30);
    check("R4", "held while run off", countNow(), 16'd10);
  endtask

  task automatic testGate();
    setCount(8'h00, 8'h00);
    countSel = 1'b0; fastBase = 1'b1; gateEn = 1'b1; gatePin = 1'b0; runEn = 1'b1;
    tick(20); check("R5", "gated low holds", countNow(), 16'd0);
    gatePin = 1'b1;
    tick(8);  check("R5", "gate high counts", countNow(), 16'd2);
    gateEn = 1'b0; gatePin = 1'b0;
    tick(4);  check("R5", "gate pin ignored", countNow(), 16'd3);
    runEn = 1'b0;
  endtask

  task automatic testCounter();
    setCount(8'h00, 8'h00);
    countSel = 1'b1; runEn = 1'b1; countPin = 1'b1;
    tick(4);
    check("R6", "no count on clock ticks", countNow(), 16'd0);
    for (int i = 0; i < 5; i++) begin
      countPin = 1'b0; tick(2);
      check("R6", "not yet counted", countNow(), 16'(i));
      tick(1);
      check("R6", "counted fall", countNow(), 16'(i + 1));
      countPin = 1'b1; tick(3);
    end
    check("R6", "rise adds nothing", countNow(), 16'd5);
    runEn = 1'b0;
    countPin = 1'b0; tick(3); countPin = 1'b1; tick(3);
    check("R4", "counter mode held while run off", countNow(), 16'd5);
    countSel = 1'b0;
  endtask

  task automatic testRipple();
    setCount(8'hFF, 8'h12);
    fastBase = 1'b1; runEn = 1'b1;
    tick(4);
    check("R7", "low wraps, spare kept", {8'h0, lowRd}, 16'h00E0);
    check("R7", "high takes carry", {8'h0, highRd}, 16'h0013);
    runEn = 1'b0;
  endtask

  task automatic testWrap();
    setCount(8'h1E, 8'hFF);
    fastBase = 1'b1; runEn = 1'b1;
    tick(7);
    check("R8", "at all ones", countNow(), 16'h1FFF);
    check("R8", "flag still clear", {15'h0, ovfFlag}, 16'h0);
    tick(1);
    check("R8", "wrapped to zero", countNow(), 16'h0000);
    check("R8", "flag set", {15'h0, ovfFlag}, 16'h1);
    runEn = 1'b0;
    intAck = 1'b1; tick(1); intAck = 1'b0;
    check("R9", "ack clears flag", {15'h0, ovfFlag}, 16'h0);
  endtask

  task automatic testFlagCollision();
    setCount(8'h1E, 8'hFF);
    fastBase = 1'b1; runEn = 1'b1;
    tick(7);
    intAck = 1'b1; flagWrEn = 1'b1; flagWrVal = 1'b0;
    tick(1);
    intAck = 1'b0; flagWrEn = 1'b0;
    check("R11", "overflow beats ack and write", {15'h0, ovfFlag}, 16'h1);
    check("R8", "wrapped during collision", countNow(), 16'h0000);
    runEn = 1'b0;
    flagWrEn = 1'b1; flagWrVal = 1'b0; tick(1);
    check("R11", "software clear", {15'h0, ovfFlag}, 16'h0);
    flagWrVal = 1'b1; tick(1);
    check("R11", "software set", {15'h0, ovfFlag}, 16'h1);
    intAck = 1'b1; flagWrVal = 1'b1; tick(1);
    intAck = 1'b0; flagWrEn = 1'b0;
    check("R11", "ack beats software set", {15'h0, ovfFlag}, 16'h0);
  endtask

  task automatic testWriteWins();
    setCount(8'h00, 8'h00);
    fastBase = 1'b1; runEn = 1'b1;
    tick(3);
    lowWrEn = 1'b1; wrData = 8'h35;
    tick(1);
    lowWrEn = 1'b0;
    check("R10", "write kept, increment lost", {8'h0, lowRd}, 16'h0035);
    check("R10", "high untouched", {8'h0, highRd}, 16'h0000);
    tick(3);
    check("R10", "prescaler restarted", {8'h0, lowRd}, 16'h0035);
    tick(1);
    check("R7", "spare bits kept on count", {8'h0, lowRd}, 16'h0036);
    runEn = 1'b0;
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testDivFour();
    testDivTwelve();
    testRunOff();
    testGate();
    testCounter();
    testRipple();
    testWrap();
    testFlagCollision();
    testWriteWins();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end
endmodule